// File: doc/BRIEF.md
# Sliced Add-Compare-Select Array for a 64-State Trellis

This block keeps the path metrics of a rate-1/2 convolutional decoder with constraint length 7 and generator masks 91 and 121 (decimal). It has 64 trellis states but only 32 add-compare-select units. Each trellis step therefore takes two clock slices. The low slice updates states 0 to 31 and the high slice updates states 32 to 63. The four branch metrics for a step stay on the inputs for both slices. Every slice puts out 32 survivor decision bits and a slice flag. When the high slice ends, the block also reports which state holds the smallest metric. A traceback stage downstream consumes these outputs.

A small controller steps through the slices. It has two states. `PH_FIRST` is the idle and low-slice state. When `step_valid` is high there, the low slice is computed and the controller moves to `PH_SECOND` (transition *accept*). `PH_SECOND` always computes the high slice, commits the new metric bank and goes back to `PH_FIRST` (transition *finish*). When `step_valid` is low in `PH_FIRST`, the controller stays put (transition *wait*). Path metrics are unsigned and wrap around. Two metrics are compared by the sign bit of their modulo difference, so the metrics never need to be renormalized.

Top module: `acs_slice_array`

## Requirements
- R1: After reset, `dec_valid` is 0 and `best_state` is 0. State 0 starts with metric 0 and every other state starts with metric 2^(PMW-2), which is 256 for PMW=10.
- R2: State s takes its two candidates from predecessors 2s mod 64 (even) and 2s+1 mod 64 (odd). Its decision bit is 1 when the odd predecessor survives.
- R3: The branch metric for the transition from predecessor p into state s is `bm_i[2*c0 + c1]`. Here c0 is the XOR of the bits of (64*u + p) AND 91, c1 is the same with 121, and u is bit 5 of s.
- R4: Each candidate is the predecessor metric plus its branch metric. The smaller candidate survives. On a tie the even predecessor survives and the decision bit is 0.
- R5: A step is accepted on a clock edge where `step_valid` is high and the block is in `PH_FIRST`. After that edge, `dec_valid`=1 and `dec_slice`=0, with `dec_bits[j]` holding the decision of state j. After the next edge, `dec_valid`=1 and `dec_slice`=1, with `dec_bits[j]` holding the decision of state 32+j.
- R6: `step_valid` is ignored during `PH_SECOND`. If it is held high continuously, the block processes one step every two cycles.
- R7: The high slice reads the metrics of the previous step, not the values just computed in the low slice of the same step.
- R8: `best_state` changes only together with a high-slice output. It then holds the lowest-numbered state whose new metric is minimal.
- R9: Decisions and `best_state` stay correct after the metrics have wrapped past 2^PMW many times.
- R10: While no step is accepted, `dec_valid` stays 0 and the metrics are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_valid | input | 1 | Request to start a trellis step |
| bm_i | input | 4 x BMW | Branch metrics indexed by the code-bit pair, held for both slices |
| dec_valid | output | 1 | Decision word valid |
| dec_slice | output | 1 | 0 = states 0..31, 1 = states 32..63 |
| dec_bits | output | 32 | Survivor decision bits of the slice |
| best_state | output | 6 | State with the smallest metric after the last step |

## Verification
The bench targets several corner cases. Equal candidates must keep the even predecessor; a design that picks the odd one sets decision bits where zeros are expected. A held `step_valid` during the high slice must not start a phantom step; if it did, `dec_valid` would appear during the idle cycles that follow. The high slice must read the old metric bank; a design that reads freshly written low-half metrics produces wrong high-slice decisions from the second step onward. A long random run pushes the metrics through many wraps. A comparator that uses magnitude instead of the sign of the difference starts choosing wrong survivors and wrong best states once the wraps begin.

// File: rtl/acs_pkg.sv
package acs_pkg;

    typedef enum logic {
        PH_FIRST  = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    // Branch metric selector for the encoder register {u, pred}
    function automatic logic [1:0] branch_sel(input int unsigned reg_bits,
                                              input int unsigned g_a,
                                              input int unsigned g_b);
        logic ca;
        logic cb;
        ca = ^(reg_bits & g_a);
        cb = ^(reg_bits & g_b);
        return {ca, cb};
    endfunction

endpackage

// File: rtl/acs_unit.sv
module acs_unit #(
    parameter int BMW = 5,
    parameter int PMW = 10
) (
    input  logic [PMW-1:0] pm_even,
    input  logic [PMW-1:0] pm_odd,
    input  logic [BMW-1:0] bm_even,
    input  logic [BMW-1:0] bm_odd,
    output logic [PMW-1:0] pm_out,
    output logic           pick_odd
);
    localparam int PADW = PMW - BMW;

    logic [PMW-1:0] cand_e;
    logic [PMW-1:0] cand_o;
    logic [PMW-1:0] diff;

    always_comb begin
        cand_e   = pm_even + {{PADW{1'b0}}, bm_even};
        cand_o   = pm_odd + {{PADW{1'b0}}, bm_odd};
        diff     = cand_o - cand_e;
        pick_odd = diff[PMW-1];
        pm_out   = pick_odd ? cand_o : cand_e;
    end
endmodule

// File: rtl/min_tree.sv
module min_tree #(
    parameter int N   = 32,
    parameter int PMW = 10,
    parameter int IW  = $clog2(N)
) (
    input  logic [PMW-1:0] vals [N],
    output logic [IW-1:0]  idx,
    output logic [PMW-1:0] val
);
    logic [PMW-1:0] wv [N];
    logic [IW-1:0]  wi [N];

    always_comb begin
        for (int i = 0; i < N; i++) begin
            wv[i] = vals[i];
            wi[i] = IW'(i);
        end
        for (int st = 1; st < N; st = st * 2) begin
            for (int i = 0; i + st < N; i = i + 2 * st) begin
                logic [PMW-1:0] d;
                d = wv[i+st] - wv[i];
                if (d[PMW-1]) begin
                    wv[i] = wv[i+st];
                    wi[i] = wi[i+st];
                end
            end
        end
        idx = wi[0];
        val = wv[0];
    end
endmodule

// File: rtl/slice_seq.sv
module slice_seq
    import acs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   step_valid,
    output phase_e phase,
    output logic   fire
);
    phase_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= PH_FIRST;
        else        phase <= nxt;
    end

    always_comb begin
        nxt  = phase;
        fire = 1'b0;
        unique case (phase)
            PH_FIRST: begin
                if (step_valid) begin
                    fire = 1'b1;
                    nxt  = PH_SECOND;
                end
            end
            PH_SECOND: begin
                fire = 1'b1;
                nxt  = PH_FIRST;
            end
        endcase
    end
endmodule

// File: rtl/acs_slice_array.sv
module acs_slice_array
    import acs_pkg::*;
#(
    parameter int K   = 7,
    parameter int G_A = 91,
    parameter int G_B = 121,
    parameter int BMW = 5,
    parameter int PMW = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      step_valid,
    input  logic [3:0][BMW-1:0]       bm_i,
    output logic                      dec_valid,
    output logic                      dec_slice,
    output logic [(1<<(K-2))-1:0]     dec_bits,
    output logic [K-2:0]              best_state
);
    localparam int SW       = K - 1;
    localparam int NS       = 1 << SW;
    localparam int NU       = NS / 2;
    localparam int IW       = SW - 1;
    localparam logic [PMW-1:0] INIT_PM = PMW'(1) << (PMW - 2);

    phase_e          phase;
    logic            fire;
    logic [PMW-1:0]  pm_q  [NS];
    logic [PMW-1:0]  stage [NU];
    logic [PMW-1:0]  nm    [NU];
    logic [NU-1:0]   dec;
    logic [IW-1:0]   sl_idx;
    logic [PMW-1:0]  sl_val;
    logic [IW-1:0]   hold_idx;
    logic [PMW-1:0]  hold_val;
    logic [PMW-1:0]  cross_d;

    slice_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_valid (step_valid),
        .phase      (phase),
        .fire       (fire)
    );

    for (genvar j = 0; j < NU; j++) begin : g_unit
        localparam int PE = 2 * j;
        localparam int PO = 2 * j + 1;
        localparam logic [1:0] SE_LO = branch_sel(PE,      G_A, G_B);
        localparam logic [1:0] SE_HI = branch_sel(PE + NS, G_A, G_B);
        localparam logic [1:0] SO_LO = branch_sel(PO,      G_A, G_B);
        localparam logic [1:0] SO_HI = branch_sel(PO + NS, G_A, G_B);
        logic [BMW-1:0] bme;
        logic [BMW-1:0] bmo;
        assign bme = bm_i[(phase == PH_SECOND) ? SE_HI : SE_LO];
        assign bmo = bm_i[(phase == PH_SECOND) ? SO_HI : SO_LO];
        acs_unit #(.BMW(BMW), .PMW(PMW)) u_acs (
            .pm_even  (pm_q[PE]),
            .pm_odd   (pm_q[PO]),
            .bm_even  (bme),
            .bm_odd   (bmo),
            .pm_out   (nm[j]),
            .pick_odd (dec[j])
        );
    end

    min_tree #(.N(NU), .PMW(PMW), .IW(IW)) u_min (
        .vals (nm),
        .idx  (sl_idx),
        .val  (sl_val)
    );

    assign cross_d = sl_val - hold_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) pm_q[i] <= (i == 0) ? '0 : INIT_PM;
            for (int i = 0; i < NU; i++) stage[i] <= '0;
            dec_valid  <= 1'b0;
            dec_slice  <= 1'b0;
            dec_bits   <= '0;
            best_state <= '0;
            hold_idx   <= '0;
            hold_val   <= '0;
        end else begin
            dec_valid <= fire;
            if (fire) begin
                dec_bits  <= dec;
                dec_slice <= (phase == PH_SECOND);
                if (phase == PH_FIRST) begin
                    stage    <= nm;
                    hold_idx <= sl_idx;
                    hold_val <= sl_val;
                end else begin
                    for (int i = 0; i < NU; i++) begin
                        pm_q[i]      <= stage[i];
                        pm_q[i + NU] <= nm[i];
                    end
                    best_state <= cross_d[PMW-1] ? {1'b1, sl_idx} : {1'b0, hold_idx};
                end
            end
        end
    end
endmodule

// File: rtl/acs_array_chk.sv
module acs_array_chk #(
    parameter int NU = 32,
    parameter int SW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          step_valid,
    input logic          dec_valid,
    input logic          dec_slice,
    input logic [NU-1:0] dec_bits,
    input logic [SW-1:0] best_state
);
    // R5
    slice_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_slice) |=> (dec_valid && dec_slice));

    // R5
    accept_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_slice) |-> $past(step_valid));

    // R6
    no_lone_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_slice) |-> $past(dec_valid && !dec_slice));

    // R8
    best_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(best_state) |-> (dec_valid && dec_slice));

    // R10
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |=> (!dec_valid || !dec_slice));
endmodule

bind acs_slice_array acs_array_chk #(.NU(NU), .SW(SW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_valid (step_valid),
    .dec_valid  (dec_valid),
    .dec_slice  (dec_slice),
    .dec_bits   (dec_bits),
    .best_state (best_state)
);

// File: tb/acs_slice_array_tb_top.sv
`timescale 1ns/1ps
module acs_slice_array_tb_top;
    localparam int BMW = 5;
    localparam int PMW = 10;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                step_valid = 1'b0;
    logic [3:0][BMW-1:0] bm_i = '0;
    logic                dec_valid;
    logic                dec_slice;
    logic [31:0]         dec_bits;
    logic [5:0]          best_state;

    int checks = 0;
    int errors = 0;
    int mdl [64];
    int nxt [64];
    logic [63:0] mdec;

    always #2.5 clk = ~clk;

    acs_slice_array dut_i (
        .clk(clk), .rst_n(rst_n), .step_valid(step_valid), .bm_i(bm_i),
        .dec_valid(dec_valid), .dec_slice(dec_slice), .dec_bits(dec_bits),
        .best_state(best_state)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int bidx(input int u, input int p);
        int r;
        r = u * 64 + p;
        return 2 * int'(^(r & 91)) + int'(^(r & 121));
    endfunction

    // reference step: R2 R3 R4
    task automatic model_step();
        for (int s = 0; s < 64; s++) begin
            int pe, c0, c1, u;
            u  = s / 32;
            pe = (2 * s) % 64;
            c0 = mdl[pe] + int'(bm_i[bidx(u, pe)]);
            c1 = mdl[pe+1] + int'(bm_i[bidx(u, pe + 1)]);
            mdec[s] = (c1 < c0);
            nxt[s]  = (c1 < c0) ? c1 : c0;
        end
    endtask

    function automatic int best_of();
        int b = 0;
        for (int s = 1; s < 64; s++) if (nxt[s] < nxt[b]) b = s;
        return b;
    endfunction

    task automatic run_step(input string tag, input bit hold);
        step_valid = 1'b1;
        model_step();
        @(posedge clk); @(negedge clk);
        chk("R5", {dec_valid, dec_slice}, 2'b10);
        chk(tag, dec_bits, mdec[31:0]);
        step_valid = hold;
        @(posedge clk); @(negedge clk);
        chk("R5", {dec_valid, dec_slice}, 2'b11);
        chk("R7", dec_bits, mdec[63:32]);
        chk("R8", best_state, best_of());
        for (int s = 0; s < 64; s++) mdl[s] = nxt[s];
        step_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        step_valid = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R10", dec_valid, 0);
        end
    endtask

    task automatic set_bm(input int a, input int b, input int c, input int d);
        bm_i[0] = BMW'(a); bm_i[1] = BMW'(b); bm_i[2] = BMW'(c); bm_i[3] = BMW'(d);
    endtask

    task automatic rand_bm();
        for (int i = 0; i < 4; i++) bm_i[i] = BMW'($urandom_range(0, 31));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        mdl[0] = 0;
        for (int s = 1; s < 64; s++) mdl[s] = 1 << (PMW - 2);
        repeat (3) @(negedge clk);
        chk("R1", {dec_valid, best_state}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", dec_valid, 0);
        // first step from reset metrics, all ties in the low half
        set_bm(0, 0, 0, 0);
        run_step("R1", 1'b0);
        idle(3);
        // one cheap code pair picks the path
        set_bm(0, 31, 31, 31);
        run_step("R3", 1'b0);
        set_bm(31, 31, 0, 31);
        run_step("R3", 1'b0);
        // held valid in the high slice must not start a step
        set_bm(5, 9, 2, 17);
        run_step("R6", 1'b1);
        idle(2);
        // warm up, then equal metrics everywhere give ties
        for (int i = 0; i < 8; i++) begin rand_bm(); run_step("R2", 1'b1); end
        for (int i = 0; i < 6; i++) begin set_bm(7, 7, 7, 7); run_step("R4", 1'b1); end
        set_bm(31, 31, 31, 31);
        run_step("R4", 1'b0);
        idle(1);
        // long random run with gaps: metrics wrap repeatedly
        for (int i = 0; i < 2500; i++) begin
            rand_bm();
            run_step("R9", 1'($urandom_range(0, 1)));
            if ($urandom_range(0, 7) == 0) idle(int'($urandom_range(1, 3)));
        end
        idle(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule